// File: doc/BRIEF.md
# Streaming Variance Assertion Monitor

This block sits beside a numeric datapath, for example a computed airspeed, and checks a statistical property of it at the full sample rate. Each accepted sample enters a sliding window of the N most recent samples (N a power of two). The block keeps a running sum and sum of squares over that window, and from them derives the window mean and variance. The property checked is Boolean: the window variance must not exceed a configured bound. While the property holds, the sample passes through unchanged. When it fails, the sample is replaced in-line by a configured safe value and a sticky exception flag is raised. Neither case stalls the stream. Software or an adaptation controller can read the flag, the per-sample check result and the statistics from extra outputs, and can use a failure to decide, for instance, that a sensor has frozen.

A three-state controller sequences the check. It has the states FILL (window not yet full, check suppressed), WATCH (check armed, no exception pending) and TRIP (exception latched). It has the transitions FILL_DONE (FILL to WATCH on the Nth accepted sample after reset), TRIP_SET (WATCH to TRIP on a failing check), TRIP_HOLD (TRIP stays on a failure or without a clear) and TRIP_CLEAR (TRIP to WATCH on a clear request with no failure at the same edge). Each sample passes through a two-register pipeline. The first register updates the window and the statistics. The second makes the decision and drives the output.

Top module: `varmon_top`

## Requirements
- R1: After reset: out_valid=0, out_data=0, chk_ok=1, exc_flag=0, armed=0, stat_mean=0, stat_var=0.
- R2: Every cycle with in_valid=1 accepts a sample, including back-to-back cycles. Each accepted sample gives exactly one out_valid=1 cycle, two rising edges after the edge that accepted it. out_valid is 0 at all other times.
- R3: stat_mean = floor(S/N), where S is the sum of the N most recently accepted samples, with zeros standing in for missing samples after reset. It updates at the edge that accepts a sample and holds while in_valid=0.
- R4: stat_var = floor((N*Q - S*S)/(N*N)), where Q is the sum of squares over the same window as S. It updates at the same edge as stat_mean.
- R5: armed rises at the edge that accepts the Nth sample after reset (FILL_DONE). A sample accepted while armed was still 0 is passed through with chk_ok=1 and never sets exc_flag, whatever the bound.
- R6: For a sample accepted while armed=1, if the window variance including that sample is at most cfg_bound, the output is that sample and chk_ok=1.
- R7: If that variance exceeds cfg_bound (strictly), out_data equals cfg_safe and chk_ok=0.
- R8: A failing check sets exc_flag at the same edge at which its substituted output appears (TRIP_SET/TRIP_HOLD).
- R9: exc_flag stays at 1 until a clear request is taken.
- R10: clr_exc=1 at an edge with exc_flag=1 and no failing check at that edge drops exc_flag (TRIP_CLEAR). A failure at the same edge keeps the flag set. clr_exc has no effect while exc_flag=0.
- R11: A sample older than the N most recent accepted samples has no effect on stat_mean or stat_var.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe, one sample per cycle |
| in_data | input | DW | Unsigned monitored sample |
| cfg_bound | input | 2*DW | Largest variance still accepted |
| cfg_safe | input | DW | Replacement value driven on a failed check |
| clr_exc | input | 1 | Request to clear the latched exception |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DW | Passed-through or substituted sample |
| chk_ok | output | 1 | Check result of the current output sample |
| exc_flag | output | 1 | Sticky exception flag |
| armed | output | 1 | Window full, check active |
| stat_mean | output | DW | Window mean |
| stat_var | output | 2*DW | Window variance |

## Verification
The bench targets the fill boundary. A monitor that armed one sample early would flag the high-variance, partly filled window of samples 0 and 255 against a bound of zero, and one that armed late would pass the first full window. It sets the bound to the exact largest variance of an alternating 0/255 stream and then to one less. An off-by-one in the comparison or a truncated variance term would pass or substitute the wrong samples. It also applies a clear at the same edge as a new failure, and a clear while no flag is set. A wrong priority drops the flag or invents one. Gapped and long sweeps check that stale samples leave the window: a design that never subtracted the departing sample would let its mean drift upward.

// File: rtl/varmon_pkg.sv
package varmon_pkg;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_WATCH = 2'd1,
        ST_TRIP  = 2'd2
    } guard_state_e;

endpackage

// File: rtl/varmon_window.sv
module varmon_window #(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] oldest
);

    for (genvar g = 0; g < DEPTH; g++) begin : gen_stage
        logic [DW-1:0] q;
        if (g == 0) begin : gen_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     q <= '0;
                else if (shift) q <= din;
            end
        end else begin : gen_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     q <= '0;
                else if (shift) q <= gen_stage[g-1].q;
            end
        end
    end

    assign oldest = gen_stage[DEPTH-1].q;

endmodule

// File: rtl/varmon_accum.sv
module varmon_accum #(
    parameter int DW    = 16,
    parameter int LOG2N = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      upd,
    input  logic [DW-1:0]             add_val,
    input  logic [DW-1:0]             sub_val,
    output logic [DW+LOG2N-1:0]       sum,
    output logic [2*DW+LOG2N-1:0]     sumsq
);

    localparam int SW = DW + LOG2N;
    localparam int QW = 2*DW + LOG2N;
    localparam logic [SW-1:0] SUM_MAX = SW'((1 << LOG2N)) * SW'((1 << DW) - 1);

    logic [SW-1:0] sum_nx;
    logic [QW-1:0] sq_add, sq_sub, sumsq_nx;

    always_comb begin
        sq_add   = QW'(add_val) * QW'(add_val);
        sq_sub   = QW'(sub_val) * QW'(sub_val);
        sum_nx   = sum + SW'(add_val) - SW'(sub_val);
        sumsq_nx = sumsq + sq_add - sq_sub;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum   <= '0;
            sumsq <= '0;
        end else if (upd) begin
            sum   <= sum_nx;
            sumsq <= sumsq_nx;
        end
    end

    // R3: the running sum can never exceed N full-scale samples
    assert_sum_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sum <= SUM_MAX);

    // R11: with no sample accepted the window totals do not move
    assert_totals_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(sum) && $stable(sumsq)));

endmodule

// File: rtl/varmon_stats.sv
module varmon_stats #(
    parameter int DW    = 16,
    parameter int LOG2N = 3
) (
    input  logic [DW+LOG2N-1:0]   sum,
    input  logic [2*DW+LOG2N-1:0] sumsq,
    output logic [DW-1:0]         mean,
    output logic [2*DW-1:0]       variance
);

    localparam int SW = DW + LOG2N;
    localparam int PW = 2*DW + 2*LOG2N;
    localparam int VW = 2*DW;

    logic [PW-1:0] sum_ext, sq_of_sum, scaled_sq, spread;

    always_comb begin
        sum_ext   = PW'(sum);
        sq_of_sum = sum_ext * sum_ext;
        scaled_sq = PW'(sumsq) << LOG2N;
        spread    = scaled_sq - sq_of_sum;
        variance  = VW'(spread >> (2*LOG2N));
        mean      = sum[SW-1:LOG2N];
    end

endmodule

// File: rtl/varmon_guard.sv
module varmon_guard
    import varmon_pkg::*;
#(
    parameter int LOG2N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_accept,
    input  logic eval_fail,
    input  logic clr,
    output logic armed,
    output logic exc_active
);

    guard_state_e state, state_nx;
    logic [LOG2N-1:0] fill_cnt;
    logic fill_last;

    assign fill_last = smp_accept && (fill_cnt == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                fill_cnt <= '0;
        else if (state == ST_FILL && smp_accept)   fill_cnt <= fill_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FILL;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL:  if (fill_last)      state_nx = ST_WATCH;   // FILL_DONE
            ST_WATCH: if (eval_fail)      state_nx = ST_TRIP;    // TRIP_SET
            ST_TRIP:  if (eval_fail)      state_nx = ST_TRIP;    // TRIP_HOLD
                      else if (clr)       state_nx = ST_WATCH;   // TRIP_CLEAR
            default:                      state_nx = ST_FILL;
        endcase
    end

    always_comb begin
        armed      = 1'b0;
        exc_active = 1'b0;
        unique case (state)
            ST_FILL:  ;
            ST_WATCH: armed = 1'b1;
            ST_TRIP:  begin armed = 1'b1; exc_active = 1'b1; end
            default:  ;
        endcase
    end

    // R5: once the window is full the guard never returns to filling
    assert_armed_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);

    // R5: no exception can be latched straight out of the fill phase
    assert_no_trip_from_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !exc_active);

endmodule

// File: rtl/varmon_top.sv
module varmon_top
    import varmon_pkg::*;
#(
    parameter int DW    = 16,
    parameter int LOG2N = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [DW-1:0]   in_data,
    input  logic [2*DW-1:0] cfg_bound,
    input  logic [DW-1:0]   cfg_safe,
    input  logic            clr_exc,
    output logic            out_valid,
    output logic [DW-1:0]   out_data,
    output logic            chk_ok,
    output logic            exc_flag,
    output logic            armed,
    output logic [DW-1:0]   stat_mean,
    output logic [2*DW-1:0] stat_var
);

    localparam int DEPTH = 1 << LOG2N;
    localparam int SW    = DW + LOG2N;
    localparam int QW    = 2*DW + LOG2N;
    localparam int VW    = 2*DW;
    localparam logic [VW-1:0] VAR_MAX = VW'((((1 << DW) - 1) * ((1 << DW) - 1)) / 4);

    logic [DW-1:0] leaving;
    logic [SW-1:0] win_sum;
    logic [QW-1:0] win_sumsq;
    logic          s1_valid;
    logic [DW-1:0] s1_data;
    logic          fail;

    varmon_window #(.DW(DW), .DEPTH(DEPTH)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift  (in_valid),
        .din    (in_data),
        .oldest (leaving)
    );

    varmon_accum #(.DW(DW), .LOG2N(LOG2N)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (in_valid),
        .add_val (in_data),
        .sub_val (leaving),
        .sum     (win_sum),
        .sumsq   (win_sumsq)
    );

    varmon_stats #(.DW(DW), .LOG2N(LOG2N)) u_stats (
        .sum      (win_sum),
        .sumsq    (win_sumsq),
        .mean     (stat_mean),
        .variance (stat_var)
    );

    assign fail = s1_valid && armed && (stat_var > cfg_bound);

    varmon_guard #(.LOG2N(LOG2N)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_accept (in_valid),
        .eval_fail  (fail),
        .clr        (clr_exc),
        .armed      (armed),
        .exc_active (exc_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_data  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) s1_data <= in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            chk_ok    <= 1'b1;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_data <= fail ? cfg_safe : s1_data;
                chk_ok   <= !fail;
            end
        end
    end

    // R2: a sample accepted two edges back must appear at the output now
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid, 2) && $past(rst_n, 1) && $past(rst_n, 2)) |-> out_valid);

    // R4: the variance of values in [0, 2^DW) cannot exceed a quarter of full scale squared
    assert_var_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_var <= VAR_MAX);

    // R3: statistics hold when no sample is accepted
    assert_stats_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(stat_mean) && $stable(stat_var)));

    // R5: before the window fills, the check never fails
    assert_quiet_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (chk_ok && !exc_flag));

    // R6: a passing sample leaves unchanged
    assert_pass_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && chk_ok) |-> (out_data == $past(in_data, 2)));

    // R7: a failing sample is replaced by the safe value
    assert_substitute_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !chk_ok) |-> (out_data == $past(cfg_safe)));

    // R8: a failure is visible on the flag together with its substituted output
    assert_flag_on_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !chk_ok) |-> exc_flag);

    // R9: without a clear the flag is sticky
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_flag && !clr_exc) |=> exc_flag);

endmodule

// File: tb/sim_varmon_top.sv
module sim_varmon_top;

    localparam int DW = 8;
    localparam int L  = 2;
    localparam int N  = 1 << L;
    localparam int VW = 2*DW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [VW-1:0] cfg_bound = '1;
    logic [DW-1:0] cfg_safe = 8'hA5;
    logic          clr_exc = 1'b0;
    logic          out_valid, chk_ok, exc_flag, armed;
    logic [DW-1:0] out_data, stat_mean;
    logic [VW-1:0] stat_var;

    varmon_top #(.DW(DW), .LOG2N(L)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .cfg_bound(cfg_bound), .cfg_safe(cfg_safe), .clr_exc(clr_exc),
        .out_valid(out_valid), .out_data(out_data), .chk_ok(chk_ok),
        .exc_flag(exc_flag), .armed(armed), .stat_mean(stat_mean), .stat_var(stat_var)
    );

    int n_chk = 0, n_fail = 0;
    longint win [N];
    int cnt;
    bit flag_e;
    bit d1_v, d2_v, d1_c, d1_bad, d2_bad, d1_arm, d2_arm;
    int d1_d, d2_d;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model_stats(output longint m, output longint v);
        longint s = 0, q = 0;
        for (int i = 0; i < N; i++) begin
            s += win[i];
            q += win[i] * win[i];
        end
        m = s / N;
        v = (N * q - s * s) / (N * N);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < N; i++) win[i] = 0;
        cnt = 0; flag_e = 0;
        d1_v = 0; d2_v = 0; d1_c = 0; d1_bad = 0; d2_bad = 0; d1_arm = 0; d2_arm = 0;
        d1_d = 0; d2_d = 0;
    endtask

    task automatic cyc(input bit v, input int d, input bit c);
        longint m, vv;
        bit bad, arm;
        @(negedge clk);
        flag_e = (d2_v && d2_bad) || (flag_e && !d1_c);
        chk("R2 out_valid", out_valid, d2_v);
        if (d2_v) begin
            if (d2_bad) begin
                chk("R7 out_data", out_data, cfg_safe);
                chk("R7 chk_ok", chk_ok, 0);
            end else if (!d2_arm) begin
                chk("R5 out_data", out_data, d2_d);
                chk("R5 chk_ok", chk_ok, 1);
            end else begin
                chk("R6 out_data", out_data, d2_d);
                chk("R6 chk_ok", chk_ok, 1);
            end
        end
        if (d1_c)                 chk("R10 exc_flag", exc_flag, flag_e);
        else if (d2_v && d2_bad)  chk("R8 exc_flag", exc_flag, flag_e);
        else                      chk("R9 exc_flag", exc_flag, flag_e);
        model_stats(m, vv);
        if (cnt > N) chk("R11 stat_mean", stat_mean, m);
        else         chk("R3 stat_mean", stat_mean, m);
        chk("R4 stat_var", stat_var, vv);
        chk("R5 armed", armed, (cnt >= N));
        bad = 0; arm = 0;
        if (v) begin
            for (int i = N - 1; i > 0; i--) win[i] = win[i-1];
            win[0] = d;
            cnt++;
            model_stats(m, vv);
            arm = (cnt >= N);
            bad = arm && (vv > longint'(cfg_bound));
        end
        d2_v = d1_v; d2_d = d1_d; d2_bad = d1_bad; d2_arm = d1_arm;
        d1_v = v;    d1_d = d;    d1_bad = bad;    d1_arm = arm;   d1_c = c;
        in_valid = v; in_data = DW'(d); clr_exc = c;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; in_valid = 0; clr_exc = 0;
        repeat (2) @(negedge clk);
        model_clear();
        rst_n = 1;
    endtask

    task automatic flush();
        repeat (3) cyc(0, 0, 0);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        model_clear();
        do_reset();
        // R1: reset state
        chk("R1 out_valid", out_valid, 0);
        chk("R1 out_data", out_data, 0);
        chk("R1 chk_ok", chk_ok, 1);
        chk("R1 exc_flag", exc_flag, 0);
        chk("R1 armed", armed, 0);
        chk("R1 stat_mean", stat_mean, 0);
        chk("R1 stat_var", stat_var, 0);

        // Full value sweep, bound wide open; clear with no flag set (R10)
        cfg_bound = '1;
        for (int i = 0; i < 256; i++) cyc(1, i, 0);
        cyc(0, 0, 1);
        flush();

        // Mixed pass/fail stream with gaps and periodic clears (R6-R11)
        cfg_bound = 16'd3000;
        for (int i = 0; i < 600; i++) cyc((i % 7) != 6, (i * 37 + 11) % 256, (i % 50) == 49);
        flush();

        // Exact bound: maximal variance equals the bound, then one above it
        do_reset();
        cfg_bound = 16'd16256;
        for (int i = 0; i < 12; i++) cyc(1, (i % 2) ? 255 : 0, 0);
        flush();
        cfg_bound = 16'd16255;
        for (int i = 0; i < 6; i++) cyc(1, (i % 2) ? 255 : 0, 0);
        flush();
        cyc(0, 0, 1);              // R10 clear taken
        flush();
        cyc(1, 0, 0);              // fails
        cyc(0, 0, 1);              // R10 clear at the failing edge loses
        cyc(0, 0, 0);
        cyc(0, 0, 1);              // R10 clear taken
        flush();

        // Fill boundary with a zero bound (R5)
        do_reset();
        cfg_bound = '0;
        for (int i = 0; i < 8; i++) cyc(1, (i % 2) ? 255 : 0, 0);
        flush();
        do_reset();
        for (int i = 0; i < 20; i++) cyc(1, 200, 0);
        flush();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule